// File: doc/BRIEF.md
# Dual-Port Line-Read Load Aligner

This block sits between a load pipeline and a data cache that has two read ports. Each read port returns a whole 64-byte line. Every cycle the block takes up to two load requests, lane A and lane B. Each request carries a byte address, a size of 1 to 32 bytes and an ID. The block picks the line index that each read port should fetch. When the lines arrive it pulls out the requested bytes, whatever their alignment. Each result is returned right-justified and zero-extended in a 256-bit word, together with the request ID.

A load that stays inside one line uses a single read port. Because every port returns the whole line, the alignment inside the line costs nothing extra. A load that runs past the end of its line uses both ports: it reads line N on one port and line N+1 on the other, and the result is stitched together from the two lines. While that happens the other lane cannot be served, so throughput drops to one load in that cycle. A request that runs past the last line of the array, or whose size is outside 1..32, is not sent to the cache. It comes back flagged as an error with zero data.

The line array is outside this block and is synchronous: a line index given in one cycle returns its line data after the next clock edge. Lane A is always accepted. Lane B has an acceptance signal and must be held or presented again when it is refused.

Top module: `ld_aligner`

## Requirements
- R1: For a valid request of size S (1..32) at byte address X that stays in one line, result byte j (bits 8j+7..8j) equals array byte X+j for j < S, and all result bytes at j >= S are zero.
- R2: When both lanes are valid and neither request crosses a line boundary, `b_ready` is 1 and both loads are served in the same cycle, at any alignment.
- R3: Two loads to the same line, including loads whose bytes overlap, are both served in the same cycle with correct data.
- R4: A lane A request that crosses from line N into line N+1 drives `rd0_en` and `rd1_en` high with `rd0_idx` = N and `rd1_idx` = N+1. Its result takes the upper bytes of line N followed by the lower bytes of line N+1.
- R5: When both lanes are valid and either request crosses a line boundary, `b_ready` is 0 and only the lane A request is served.
- R6: A request accepted in cycle c produces its result valid in cycle c+2 with the same ID. Both lanes can complete in the same cycle.
- R7: A request whose size is 0 or above 32, or whose last byte lies beyond the end of the array, returns err = 1 with all-zero data. It enables no read port.
- R8: While reset is asserted and in the first cycle after it, no result is valid.
- R9: A lane B request that crosses a line boundary while lane A is idle is served alone. It uses both read ports, with `rd0_idx` = N and `rd1_idx` = N+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | Lane A request present (always accepted) |
| a_addr | input | 10 | Lane A byte address |
| a_size | input | 6 | Lane A size in bytes |
| a_id | input | 4 | Lane A request ID |
| b_valid | input | 1 | Lane B request present |
| b_addr | input | 10 | Lane B byte address |
| b_size | input | 6 | Lane B size in bytes |
| b_id | input | 4 | Lane B request ID |
| b_ready | output | 1 | Lane B request accepted this cycle |
| rd0_en | output | 1 | Read port 0 enable |
| rd0_idx | output | 4 | Read port 0 line index |
| rd0_line | input | 512 | Read port 0 line data, one cycle after enable |
| rd1_en | output | 1 | Read port 1 enable |
| rd1_idx | output | 4 | Read port 1 line index |
| rd1_line | input | 512 | Read port 1 line data, one cycle after enable |
| ra_valid | output | 1 | Lane A result valid |
| ra_id | output | 4 | Lane A result ID |
| ra_err | output | 1 | Lane A result error flag |
| ra_data | output | 256 | Lane A result data |
| rb_valid | output | 1 | Lane B result valid |
| rb_id | output | 4 | Lane B result ID |
| rb_err | output | 1 | Lane B result error flag |
| rb_data | output | 256 | Lane B result data |

## Verification
The directed patterns each isolate one case:
- two loads in different lines, which exposes a wrong port assignment;
- two overlapping loads in one line, which exposes a lane picking up the other lane's offset;
- single-byte and full 32-byte loads at the very end of a line, which exposes a wrong boundary between in-line and crossing;
- a crossing load on lane A with lane B waiting, and a crossing load on lane B alone, which expose a merge that takes the two halves from the wrong ports.

Error cases cover size zero, size 33 and a load hanging off the last line. These tell a refused request apart from one that is quietly truncated. A long run of random requests with addresses spread over the array then compares every result, ID and `b_ready` against a byte-level model of the array.

// File: rtl/ldal_pkg.sv
package ldal_pkg;
  localparam int NLANES = 2;
  localparam int LANE_A = 0;
  localparam int LANE_B = 1;
endpackage

// File: rtl/ldal_route.sv
// Request decode and read-port assignment: classifies each lane as
// in-line, crossing or bad, then chooses which lines the two ports fetch.
module ldal_route
  import ldal_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int MAX_BYTES  = 32,
  parameter int NUM_LINES  = 16,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int TOTAL  = NUM_LINES * LINE_BYTES,
  localparam int ADDR_W = $clog2(TOTAL),
  localparam int IDX_W  = ADDR_W - OFF_W,
  localparam int SIZE_W = $clog2(MAX_BYTES + 1)
) (
  input  logic [NLANES-1:0]             req_v,
  input  logic [NLANES-1:0][ADDR_W-1:0] req_addr,
  input  logic [NLANES-1:0][SIZE_W-1:0] req_size,
  output logic [NLANES-1:0]             acc,
  output logic [NLANES-1:0]             bad,
  output logic [NLANES-1:0]             crs,
  output logic                          b_ready,
  output logic                          rd0_en,
  output logic [IDX_W-1:0]              rd0_idx,
  output logic                          rd1_en,
  output logic [IDX_W-1:0]              rd1_idx
);
  localparam logic [ADDR_W:0]   TOTAL_V = (ADDR_W + 1)'(TOTAL);
  localparam logic [SIZE_W-1:0] MAX_V   = SIZE_W'(MAX_BYTES);

  logic [NLANES-1:0][IDX_W-1:0] first_idx;
  logic [NLANES-1:0][IDX_W-1:0] last_idx;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    logic [ADDR_W:0] last_b;
    always_comb begin
      last_b       = {1'b0, req_addr[i]} + (ADDR_W + 1)'(req_size[i]) - 1'b1;
      bad[i]       = (req_size[i] == '0) || (req_size[i] > MAX_V) || (last_b >= TOTAL_V);
      first_idx[i] = req_addr[i][ADDR_W-1:OFF_W];
      last_idx[i]  = last_b[ADDR_W-1:OFF_W];
      crs[i]       = !bad[i] && (last_idx[i] != first_idx[i]);
    end
  end

  always_comb begin
    b_ready     = !req_v[LANE_A] || (!crs[LANE_A] && !crs[LANE_B]);
    acc[LANE_A] = req_v[LANE_A];
    acc[LANE_B] = req_v[LANE_B] && b_ready;

    rd0_en  = 1'b0;
    rd0_idx = first_idx[LANE_A];
    if (acc[LANE_A] && !bad[LANE_A]) begin
      rd0_en  = 1'b1;
      rd0_idx = first_idx[LANE_A];
    end else if (acc[LANE_B] && crs[LANE_B]) begin
      rd0_en  = 1'b1;
      rd0_idx = first_idx[LANE_B];
    end

    rd1_en  = 1'b0;
    rd1_idx = first_idx[LANE_B];
    if (acc[LANE_A] && crs[LANE_A]) begin
      rd1_en  = 1'b1;
      rd1_idx = last_idx[LANE_A];
    end else if (acc[LANE_B] && !bad[LANE_B]) begin
      rd1_en  = 1'b1;
      rd1_idx = crs[LANE_B] ? last_idx[LANE_B] : first_idx[LANE_B];
    end
  end
endmodule

// File: rtl/ldal_extract.sv
// Byte extraction from a pair of lines: byte j of the result is byte
// (offset + j) of {hi_line, lo_line}, masked by size and by the error flag.
module ldal_extract #(
  parameter int LINE_BYTES = 64,
  parameter int MAX_BYTES  = 32,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int SIZE_W = $clog2(MAX_BYTES + 1),
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int DATA_W = MAX_BYTES * 8,
  localparam int SEL_W  = OFF_W + 1
) (
  input  logic [LINE_W-1:0] lo_line,
  input  logic [LINE_W-1:0] hi_line,
  input  logic [OFF_W-1:0]  off,
  input  logic [SIZE_W-1:0] size,
  input  logic              err,
  output logic [DATA_W-1:0] data
);
  logic [2*LINE_W-1:0] pair;
  assign pair = {hi_line, lo_line};

  for (genvar j = 0; j < MAX_BYTES; j++) begin : g_byte
    logic [SEL_W-1:0] sel;
    logic             keep;
    always_comb begin
      sel  = {1'b0, off} + SEL_W'(j);
      keep = !err && (SIZE_W'(j) < size);
      data[j*8 +: 8] = keep ? pair[sel*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/ld_aligner.sv
// Top: two load lanes, two whole-line read ports, fixed two-cycle latency.
module ld_aligner
  import ldal_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int MAX_BYTES  = 32,
  parameter int NUM_LINES  = 16,
  parameter int ID_W       = 4,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int ADDR_W = $clog2(NUM_LINES * LINE_BYTES),
  localparam int IDX_W  = ADDR_W - OFF_W,
  localparam int SIZE_W = $clog2(MAX_BYTES + 1),
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int DATA_W = MAX_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_valid,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [SIZE_W-1:0] a_size,
  input  logic [ID_W-1:0]   a_id,
  input  logic              b_valid,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [SIZE_W-1:0] b_size,
  input  logic [ID_W-1:0]   b_id,
  output logic              b_ready,
  output logic              rd0_en,
  output logic [IDX_W-1:0]  rd0_idx,
  input  logic [LINE_W-1:0] rd0_line,
  output logic              rd1_en,
  output logic [IDX_W-1:0]  rd1_idx,
  input  logic [LINE_W-1:0] rd1_line,
  output logic              ra_valid,
  output logic [ID_W-1:0]   ra_id,
  output logic              ra_err,
  output logic [DATA_W-1:0] ra_data,
  output logic              rb_valid,
  output logic [ID_W-1:0]   rb_id,
  output logic              rb_err,
  output logic [DATA_W-1:0] rb_data
);
  logic [NLANES-1:0]             acc, bad, crs;
  logic [NLANES-1:0][ADDR_W-1:0] req_addr;
  logic [NLANES-1:0][SIZE_W-1:0] req_size;
  logic [NLANES-1:0][ID_W-1:0]   req_id;

  assign req_addr = {b_addr, a_addr};
  assign req_size = {b_size, a_size};
  assign req_id   = {b_id, a_id};

  ldal_route #(
    .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES), .NUM_LINES(NUM_LINES)
  ) u_route (
    .req_v   ({b_valid, a_valid}),
    .req_addr(req_addr),
    .req_size(req_size),
    .acc     (acc),
    .bad     (bad),
    .crs     (crs),
    .b_ready (b_ready),
    .rd0_en  (rd0_en),
    .rd0_idx (rd0_idx),
    .rd1_en  (rd1_en),
    .rd1_idx (rd1_idx)
  );

  // Stage 1: request meta travels alongside the line read.
  logic [NLANES-1:0]             s1_v, s1_err;
  logic [NLANES-1:0][ID_W-1:0]   s1_id;
  logic [NLANES-1:0][OFF_W-1:0]  s1_off;
  logic [NLANES-1:0][SIZE_W-1:0] s1_size;
  logic                          s1_b_lo0;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v     <= '0;
      s1_err   <= '0;
      s1_id    <= '0;
      s1_off   <= '0;
      s1_size  <= '0;
      s1_b_lo0 <= 1'b0;
    end else begin
      s1_v     <= acc;
      s1_err   <= bad;
      s1_b_lo0 <= crs[LANE_B];
      for (int i = 0; i < NLANES; i++) begin
        s1_id[i]   <= req_id[i];
        s1_off[i]  <= req_addr[i][OFF_W-1:0];
        s1_size[i] <= req_size[i];
      end
    end
  end

  // Stage 2: extraction and result registers.
  logic [NLANES-1:0][LINE_W-1:0] lo_sel;
  logic [NLANES-1:0][DATA_W-1:0] ext;

  assign lo_sel[LANE_A] = rd0_line;
  assign lo_sel[LANE_B] = s1_b_lo0 ? rd0_line : rd1_line;

  for (genvar i = 0; i < NLANES; i++) begin : g_ext
    ldal_extract #(.LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES)) u_ext (
      .lo_line(lo_sel[i]),
      .hi_line(rd1_line),
      .off    (s1_off[i]),
      .size   (s1_size[i]),
      .err    (s1_err[i]),
      .data   (ext[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_valid <= 1'b0;
      ra_id    <= '0;
      ra_err   <= 1'b0;
      ra_data  <= '0;
      rb_valid <= 1'b0;
      rb_id    <= '0;
      rb_err   <= 1'b0;
      rb_data  <= '0;
    end else begin
      ra_valid <= s1_v[LANE_A];
      ra_id    <= s1_id[LANE_A];
      ra_err   <= s1_err[LANE_A];
      ra_data  <= ext[LANE_A];
      rb_valid <= s1_v[LANE_B];
      rb_id    <= s1_id[LANE_B];
      rb_err   <= s1_err[LANE_B];
      rb_data  <= ext[LANE_B];
    end
  end
endmodule

// File: rtl/ld_aligner_chk.sv
module ld_aligner_chk #(
  parameter int LINE_BYTES = 64,
  parameter int MAX_BYTES  = 32,
  parameter int NUM_LINES  = 16,
  parameter int ID_W       = 4,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int ADDR_W = $clog2(NUM_LINES * LINE_BYTES),
  localparam int IDX_W  = ADDR_W - OFF_W,
  localparam int SIZE_W = $clog2(MAX_BYTES + 1),
  localparam int DATA_W = MAX_BYTES * 8
) (
  input logic              clk,
  input logic              rst,
  input logic              a_valid,
  input logic [ADDR_W-1:0] a_addr,
  input logic [SIZE_W-1:0] a_size,
  input logic [ID_W-1:0]   a_id,
  input logic              b_valid,
  input logic [ADDR_W-1:0] b_addr,
  input logic [SIZE_W-1:0] b_size,
  input logic              b_ready,
  input logic              rd0_en,
  input logic [IDX_W-1:0]  rd0_idx,
  input logic              rd1_en,
  input logic [IDX_W-1:0]  rd1_idx,
  input logic              ra_valid,
  input logic [ID_W-1:0]   ra_id,
  input logic              ra_err,
  input logic [DATA_W-1:0] ra_data,
  input logic              rb_valid,
  input logic              rb_err,
  input logic [DATA_W-1:0] rb_data
);
  localparam int TOTAL = NUM_LINES * LINE_BYTES;
  int  end_a, end_b;
  logic ea, eb, xa, xb;

  always_comb begin
    end_a = int'(a_addr) + int'(a_size) - 1;
    end_b = int'(b_addr) + int'(b_size) - 1;
    ea = (a_size == 0) || (int'(a_size) > MAX_BYTES) || (end_a >= TOTAL);
    eb = (b_size == 0) || (int'(b_size) > MAX_BYTES) || (end_b >= TOTAL);
    xa = !ea && ((end_a / LINE_BYTES) != (int'(a_addr) / LINE_BYTES));
    xb = !eb && ((end_b / LINE_BYTES) != (int'(b_addr) / LINE_BYTES));
  end

  a_r2_pair_ready: assert property (@(posedge clk) disable iff (rst)
    (a_valid && b_valid && !xa && !xb) |-> b_ready);

  a_r5_split_stall: assert property (@(posedge clk) disable iff (rst)
    (a_valid && b_valid && (xa || xb)) |-> !b_ready);

  a_r4_split_ports: assert property (@(posedge clk) disable iff (rst)
    (a_valid && xa) |-> (rd0_en && rd1_en && rd1_idx == IDX_W'(rd0_idx + 1'b1)));

  a_r6_latency_a: assert property (@(posedge clk) disable iff (rst)
    a_valid |=> ##1 ra_valid);

  a_r6_id_a: assert property (@(posedge clk) disable iff (rst)
    a_valid |=> ##1 (ra_id == $past(a_id, 2)));

  a_r7_zero_a: assert property (@(posedge clk) disable iff (rst)
    (ra_valid && ra_err) |-> (ra_data == '0));

  a_r7_zero_b: assert property (@(posedge clk) disable iff (rst)
    (rb_valid && rb_err) |-> (rb_data == '0));

  a_r7_no_port: assert property (@(posedge clk) disable iff (rst)
    (a_valid && ea && !(b_valid && !eb)) |-> (!rd0_en && !rd1_en));

  a_r8_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ra_valid && !rb_valid));
endmodule

bind ld_aligner ld_aligner_chk #(
  .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES), .NUM_LINES(NUM_LINES), .ID_W(ID_W)
) u_chk (.*);

// File: tb/ld_aligner_test.sv
module ld_aligner_test;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_BYTES = 64;
  localparam int MAX_BYTES  = 32;
  localparam int NUM_LINES  = 16;
  localparam int ID_W       = 4;
  localparam int TOTAL  = NUM_LINES * LINE_BYTES;
  localparam int ADDR_W = $clog2(TOTAL);
  localparam int IDX_W  = ADDR_W - $clog2(LINE_BYTES);
  localparam int SIZE_W = $clog2(MAX_BYTES + 1);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int DATA_W = MAX_BYTES * 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_valid = 1'b0, b_valid = 1'b0;
  logic [ADDR_W-1:0] a_addr = '0, b_addr = '0;
  logic [SIZE_W-1:0] a_size = '0, b_size = '0;
  logic [ID_W-1:0] a_id = '0, b_id = '0;
  logic b_ready, rd0_en, rd1_en;
  logic [IDX_W-1:0] rd0_idx, rd1_idx;
  logic [LINE_W-1:0] rd0_line = '0, rd1_line = '0;
  logic ra_valid, ra_err, rb_valid, rb_err;
  logic [ID_W-1:0] ra_id, rb_id;
  logic [DATA_W-1:0] ra_data, rb_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ld_aligner #(.LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES),
               .NUM_LINES(NUM_LINES), .ID_W(ID_W)) uut (.*);

  function automatic logic [7:0] memb(int a);
    return 8'((a * 29 + 7 + (a / 64) * 3) & 255);
  endfunction

  // Synchronous line array model.
  logic [LINE_W-1:0] mem [NUM_LINES];
  initial begin
    for (int l = 0; l < NUM_LINES; l++)
      for (int j = 0; j < LINE_BYTES; j++)
        mem[l][j*8 +: 8] = memb(l * LINE_BYTES + j);
  end
  always @(posedge clk) begin
    if (rd0_en) rd0_line <= mem[rd0_idx];
    if (rd1_en) rd1_line <= mem[rd1_idx];
  end

  typedef struct {
    bit v;
    bit [ID_W-1:0] id;
    bit e;
    bit [DATA_W-1:0] d;
    string tag;
  } exp_t;

  exp_t pa0, pb0, pa1, pb1;
  int n_tests = 0, n_fail = 0;

  task automatic check(string req, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit is_bad(int addr, int size);
    return (size == 0) || (size > MAX_BYTES) || (addr + size - 1 >= TOTAL);
  endfunction

  function automatic bit is_cross(int addr, int size);
    return !is_bad(addr, size) && ((addr + size - 1) / LINE_BYTES != addr / LINE_BYTES);
  endfunction

  function automatic logic [DATA_W-1:0] expect_data(int addr, int size);
    logic [DATA_W-1:0] d = '0;
    if (!is_bad(addr, size))
      for (int j = 0; j < size; j++) d[j*8 +: 8] = memb(addr + j);
    return d;
  endfunction

  task automatic cmp_lane(exp_t e, string ln, logic v, logic [ID_W-1:0] id, logic er,
                          logic [DATA_W-1:0] d);
    check("R6", {ln, " valid"}, DATA_W'(v), DATA_W'(e.v));
    if (e.v) begin
      check("R6", {ln, " id"}, DATA_W'(id), DATA_W'(e.id));
      check("R7", {ln, " err"}, DATA_W'(er), DATA_W'(e.e));
      check(e.tag, {ln, " data"}, d, e.d);
    end
  endtask

  task automatic step(bit av, int aa, int asz, int aid, bit bv, int ba, int bsz, int bid);
    bit xa, xb, ea, eb, accb;
    @(negedge clk);
    cmp_lane(pa1, "lane A", ra_valid, ra_id, ra_err, ra_data);
    cmp_lane(pb1, "lane B", rb_valid, rb_id, rb_err, rb_data);
    pa1 = pa0;
    pb1 = pb0;
    a_valid = av; a_addr = ADDR_W'(aa); a_size = SIZE_W'(asz); a_id = ID_W'(aid);
    b_valid = bv; b_addr = ADDR_W'(ba); b_size = SIZE_W'(bsz); b_id = ID_W'(bid);
    ea = is_bad(aa, asz); eb = is_bad(ba, bsz);
    xa = is_cross(aa, asz); xb = is_cross(ba, bsz);
    accb = bv && (!av || (!xa && !xb));
    pa0.v = av; pa0.id = ID_W'(aid); pa0.e = ea; pa0.d = expect_data(aa, asz);
    pa0.tag = ea ? "R7" : (xa ? "R4" : "R1");
    pb0.v = accb; pb0.id = ID_W'(bid); pb0.e = eb; pb0.d = expect_data(ba, bsz);
    pb0.tag = eb ? "R7" : (xb ? "R9" :
              ((av && !xa && !ea && aa / LINE_BYTES == ba / LINE_BYTES) ? "R3" : "R1"));
    #1;
    if (bv) check((xa || xb) && av ? "R5" : "R2", "b_ready", DATA_W'(b_ready), DATA_W'(accb));
    if ((av && xa) || (!av && accb && xb)) begin
      int n = (av ? aa : ba) / LINE_BYTES;
      string t = av ? "R4" : "R9";
      check(t, "split port enables", DATA_W'({rd0_en, rd1_en}), DATA_W'(2'b11));
      check(t, "split rd0_idx", DATA_W'(rd0_idx), DATA_W'(n));
      check(t, "split rd1_idx", DATA_W'(rd1_idx), DATA_W'(n + 1));
    end
    if ((av || bv) && (!av || ea) && (!accb || eb))
      check("R7", "port enables for bad request", DATA_W'({rd0_en, rd1_en}), '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    pa0 = '{default: 0, tag: "R1"}; pb0 = pa0; pa1 = pa0; pb1 = pa0;
    repeat (3) @(negedge clk);
    check("R8", "valid during reset", DATA_W'({ra_valid, rb_valid}), '0);
    rst = 1'b0;
    @(negedge clk);
    check("R8", "valid after reset", DATA_W'({ra_valid, rb_valid}), '0);

    // R1 R2: two in-line loads, different lines, different alignments
    step(1, 0, 32, 1, 1, 64 + 17, 5, 2);
    // R3: overlapping loads in the same line
    step(1, 128 + 10, 20, 3, 1, 128 + 20, 16, 4);
    // R1: one byte at the last offset of a line; full size ending on the line end
    step(1, 63, 1, 5, 1, 192 + 32, 32, 6);
    // R4 R5: lane A crosses, lane B stalled
    step(1, 64 + 50, 20, 7, 1, 300, 4, 8);
    // R9: lane B crosses alone
    step(0, 0, 0, 0, 1, 256 + 60, 8, 9);
    // R5: lane B crosses while lane A is in-line
    step(1, 400, 8, 10, 1, 448 + 40, 32, 11);
    // R4: offset 33 with size 32 just crosses
    step(1, 512 + 33, 32, 12, 0, 0, 0, 0);
    // R7: past the array end, size zero, size too large
    step(1, TOTAL - 4, 8, 13, 0, 0, 0, 0);
    step(1, 10, 0, 14, 1, 20, 33, 15);
    step(1, TOTAL - 1, 1, 1, 1, TOTAL - 32, 32, 2);
    step(1, TOTAL - 2, 3, 3, 1, 70, 9, 4);
    for (int k = 0; k < 600; k++)
      step($urandom_range(0, 9) < 8, $urandom_range(0, TOTAL - 1), $urandom_range(0, 34),
           $urandom_range(0, 15), $urandom_range(0, 9) < 7, $urandom_range(0, TOTAL - 1),
           $urandom_range(0, 34), $urandom_range(0, 15));
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule